// File: doc/BRIEF.md
# Streaming Spatio-Temporal Gradient Unit

This block takes two raster pixel streams that arrive in lockstep, one beat per clock. The first is the previous frame read back from frame storage. The second is the current frame arriving live from the sensor. For each pixel position it produces three signed gradients on a single output beat:

- a horizontal spatial gradient and a vertical spatial gradient, both taken on the previous frame;
- a temporal gradient, taken as the current frame minus the previous frame.

The previous-frame stream runs through a delay chain two lines deep, which exposes the four neighbours of a centre pixel. The current-frame stream is delayed by one line plus one pixel so that it lines up with that centre. The spatial gradients use a central difference halved by an arithmetic shift, so no divider is needed. Any gradient whose magnitude is below the programmable `noise_floor` is forced to zero. A typical setting for `noise_floor` is 5. Pixels in the outermost rows and columns have no full neighbourhood. For these the block outputs zero gradients and raises a border flag.

Both stream edges use valid/ready handshakes. Image width and height are module parameters. A start-of-frame bit on the input beat resets the raster position.

Top module: `stg_gradient_unit`

## Requirements
- R1: For an interior centre at (row, col), `out_dx` equals (P[row][col+1] − P[row][col−1]) shifted right arithmetically by one (rounding toward minus infinity), as a 9-bit two's-complement value in the range −128..127. P is the previous frame. The dead zone of R4 is then applied.
- R2: For an interior centre, `out_dy` equals (P[row+1][col] − P[row−1][col]) shifted right arithmetically by one, as a 9-bit two's-complement value in the range −128..127. The dead zone of R4 is then applied.
- R3: For an interior centre, `out_dt` equals C[row][col] − P[row][col] as a 9-bit two's-complement value. C is the current frame. The dead zone of R4 is then applied.
- R4: Each gradient whose absolute value is strictly below the `noise_floor` value sampled on the accepting beat is output as 0. A magnitude equal to or above that value passes unchanged. A value of 0 disables the dead zone.
- R5: When the centre lies in row 0, row IMG_H−1, column 0 or column IMG_W−1, all three gradients are 0 and `out_border` is 1. At every interior centre `out_border` is 0.
- R6: Input beats are numbered k from the beat that carries `in_sof` (k = 0). Beats 0 to IMG_W produce no output. Each accepted beat with k ≥ IMG_W+1 produces exactly one output, for the centre with raster index k−IMG_W−1, and that output is presented in the cycle after the beat is accepted.
- R7: While `out_valid` is 1 and `out_ready` is 0, all outputs hold and `in_ready` is 0. Otherwise `in_ready` is 1.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1 until a producing beat is accepted.
- R9: A beat with `in_sof` set restarts the raster position even in the middle of a frame. The output then follows R6 counted from that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| noise_floor | input | 8 | Dead-zone magnitude threshold |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_sof | input | 1 | Beat is the first pixel of a frame |
| in_prev | input | 8 | Previous-frame pixel, unsigned |
| in_curr | input | 8 | Current-frame pixel, unsigned, same position |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts output beat |
| out_dx | output | 9 | Horizontal gradient, two's complement |
| out_dy | output | 9 | Vertical gradient, two's complement |
| out_dt | output | 9 | Temporal gradient, two's complement |
| out_border | output | 1 | Centre lies on the outermost row or column |

## Verification
Three behaviours are hard to reach from the ports.

The first is a backpressure stall that lands on the edge of a fill window, including the beat that carries `in_sof`. The stimulus covers it by combining random input gaps with random and mostly-low `out_ready` phases. It also cuts one frame short and restarts it with a mid-frame start-of-frame beat.

The second is the dead-zone edge. One pattern makes the horizontal gradient exactly equal to the threshold and sets the temporal difference to ±threshold and ±(threshold−1).

The third is the extremes of the halving shift. A 0/255 column pattern reaches both +127 and −128.

// File: rtl/stg_pkg.sv
package stg_pkg;
  localparam int PIX_W  = 8;
  localparam int GRAD_W = PIX_W + 1;

  typedef logic [PIX_W-1:0]         pix_t;
  typedef logic signed [GRAD_W-1:0] grad_t;

  typedef struct packed {
    grad_t dx;
    grad_t dy;
    grad_t dt;
    logic  border;
  } grad_beat_t;

  // Difference of two unsigned pixels as a signed gradient-width value
  function automatic grad_t pix_diff(pix_t a, pix_t b);
    return grad_t'({1'b0, a}) - grad_t'({1'b0, b});
  endfunction
endpackage

// File: rtl/stg_tap_line.sv
module stg_tap_line
  import stg_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  pix_t din,
  output pix_t dout
);
  logic [DEPTH-1:0][PIX_W-1:0] chain_q;
  logic [DEPTH-1:0][PIX_W-1:0] shifted;
  logic [DEPTH-1:0][PIX_W-1:0] chain_d;

  generate
    if (DEPTH == 1) begin : g_single
      assign shifted = din;
    end else begin : g_multi
      assign shifted = {chain_q[DEPTH-2:0], din};
    end
  endgenerate

  always_comb begin
    chain_d = en ? shifted : chain_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[DEPTH-1];
endmodule

// File: rtl/stg_raster_pos.sv
module stg_raster_pos #(
  parameter int IMG_W = 16,
  parameter int IMG_H = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic sof,
  output logic emit,
  output logic cen_border
);
  localparam int COL_W = $clog2(IMG_W);
  localparam int ROW_W = $clog2(IMG_H);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(IMG_W - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(IMG_H - 1);

  logic [COL_W-1:0] col_q, col_d, eff_col, cen_col;
  logic [ROW_W-1:0] row_q, row_d, eff_row, cen_row;

  always_comb begin
    eff_col = sof ? '0 : col_q;
    eff_row = sof ? '0 : row_q;
    col_d   = col_q;
    row_d   = row_q;
    if (step) begin
      col_d = (eff_col == COL_LAST) ? '0 : eff_col + 1'b1;
      if (eff_col == COL_LAST) row_d = (eff_row == ROW_LAST) ? '0 : eff_row + 1'b1;
      else                     row_d = eff_row;
    end
    // centre sits one line plus one pixel behind the incoming beat
    emit    = (eff_row >= ROW_W'(2)) || ((eff_row == ROW_W'(1)) && (eff_col != '0));
    cen_col = (eff_col == '0) ? COL_LAST : eff_col - 1'b1;
    cen_row = (eff_col == '0) ? eff_row - ROW_W'(2) : eff_row - ROW_W'(1);
    cen_border = (cen_row == '0) || (cen_row == ROW_LAST) ||
                 (cen_col == '0) || (cen_col == COL_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  assert_col_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q <= COL_LAST) && (row_q <= ROW_LAST));
  assert_sof_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sof) |=> (col_q == COL_W'(1 % IMG_W)));
endmodule

// File: rtl/stg_deadzone.sv
module stg_deadzone
  import stg_pkg::*;
(
  input  grad_t raw,
  input  pix_t  floor_val,
  output grad_t res
);
  logic [GRAD_W-1:0] mag;

  always_comb begin
    mag = raw[GRAD_W-1] ? $unsigned(-raw) : $unsigned(raw);
    res = (mag < {1'b0, floor_val}) ? '0 : raw;
  end
endmodule

// File: rtl/stg_gradient_unit.sv
module stg_gradient_unit
  import stg_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter int IMG_H = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [stg_pkg::PIX_W-1:0] noise_floor,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_sof,
  input  logic [stg_pkg::PIX_W-1:0] in_prev,
  input  logic [stg_pkg::PIX_W-1:0] in_curr,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [stg_pkg::PIX_W:0]   out_dx,
  output logic [stg_pkg::PIX_W:0]   out_dy,
  output logic [stg_pkg::PIX_W:0]   out_dt,
  output logic                      out_border
);
  localparam int N_GRAD = 3;
  localparam int SEG_W  = IMG_W - 1;
  localparam int CUR_DLY = IMG_W + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic in_fire, emit, cen_border;
  assign in_ready = out_ready | ~out_valid;
  assign in_fire  = in_valid & in_ready;

  stg_raster_pos #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_pos (
    .clk(clk), .rst_n(rst_sync_n), .step(in_fire), .sof(in_sof),
    .emit(emit), .cen_border(cen_border));

  // previous-frame taps: down=k-1, right=k-W, centre=k-W-1, left=k-W-2, up=k-2W-1
  pix_t t_down, t_right, t_ctr, t_left, t_up, c_ctr;
  stg_tap_line #(.DEPTH(1))     u_p_down  (.clk(clk), .rst_n(rst_sync_n), .en(in_fire), .din(in_prev), .dout(t_down));
  stg_tap_line #(.DEPTH(SEG_W)) u_p_right (.clk(clk), .rst_n(rst_sync_n), .en(in_fire), .din(t_down),  .dout(t_right));
  stg_tap_line #(.DEPTH(1))     u_p_ctr   (.clk(clk), .rst_n(rst_sync_n), .en(in_fire), .din(t_right), .dout(t_ctr));
  stg_tap_line #(.DEPTH(1))     u_p_left  (.clk(clk), .rst_n(rst_sync_n), .en(in_fire), .din(t_ctr),   .dout(t_left));
  stg_tap_line #(.DEPTH(SEG_W)) u_p_up    (.clk(clk), .rst_n(rst_sync_n), .en(in_fire), .din(t_left),  .dout(t_up));
  stg_tap_line #(.DEPTH(CUR_DLY)) u_c_ctr (.clk(clk), .rst_n(rst_sync_n), .en(in_fire), .din(in_curr), .dout(c_ctr));

  grad_t raw_g [N_GRAD];
  grad_t dz_g  [N_GRAD];
  grad_t hx, hy;

  always_comb begin
    hx = pix_diff(t_right, t_left);
    hy = pix_diff(t_down, t_up);
    raw_g[0] = hx >>> 1;
    raw_g[1] = hy >>> 1;
    raw_g[2] = pix_diff(c_ctr, t_ctr);
  end

  generate
    for (genvar g = 0; g < N_GRAD; g++) begin : g_dz
      stg_deadzone u_dz (.raw(raw_g[g]), .floor_val(noise_floor), .res(dz_g[g]));
    end
  endgenerate

  grad_beat_t beat_new, beat_q, beat_d;
  logic       valid_q, valid_d;

  always_comb begin
    if (cen_border) beat_new = '{dx: '0, dy: '0, dt: '0, border: 1'b1};
    else            beat_new = '{dx: dz_g[0], dy: dz_g[1], dt: dz_g[2], border: 1'b0};
    valid_d = in_ready ? (in_fire & emit) : valid_q;
    beat_d  = in_ready ? beat_new : beat_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
    end else begin
      valid_q <= valid_d;
      beat_q  <= beat_d;
    end
  end

  assign out_valid  = valid_q;
  assign out_dx     = beat_q.dx;
  assign out_dy     = beat_q.dy;
  assign out_dt     = beat_q.dt;
  assign out_border = beat_q.border;

  // checks on the registered outputs
  logic [GRAD_W-1:0] chk_dt_mag, chk_floor;
  always_comb begin
    chk_dt_mag = out_dt[GRAD_W-1] ? (~out_dt + 1'b1) : out_dt;
    chk_floor  = {1'b0, noise_floor};
  end

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dx) && $stable(out_dy) &&
                                   $stable(out_dt) && $stable(out_border)));
  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_ready) |-> !in_ready);
  assert_sof_no_output_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_ready && in_sof) |=> !out_valid);
  assert_border_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_border) |-> (out_dx == '0 && out_dy == '0 && out_dt == '0));
  assert_dx_range_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> ($signed(out_dx) >= -9'sd128 && $signed(out_dx) <= 9'sd127));
  assert_dy_range_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> ($signed(out_dy) >= -9'sd128 && $signed(out_dy) <= 9'sd127));
  assert_deadzone_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(in_valid && in_ready) && out_valid && out_dt != '0) |-> (chk_dt_mag >= $past(chk_floor)));
endmodule

// File: tb/stg_gradient_unit_tb.sv
module stg_gradient_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int H = 6;
  localparam int NPX = W * H;

  logic       clk, rst_n;
  logic [7:0] noise_floor;
  logic       in_valid, in_ready, in_sof;
  logic [7:0] in_prev, in_curr;
  logic       out_valid, out_ready;
  logic [8:0] out_dx, out_dy, out_dt;
  logic       out_border;

  stg_gradient_unit #(.IMG_W(W), .IMG_H(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .noise_floor(noise_floor),
    .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
    .in_prev(in_prev), .in_curr(in_curr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_dx(out_dx), .out_dy(out_dy), .out_dt(out_dt), .out_border(out_border));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit started = 0;
  bit finished = 0;
  int rdy_mode = 0;
  bit gap_mode = 0;

  // reference model state
  int pf [NPX];
  int cf [NPX];
  int mk = -1;
  int q_dx[$], q_dy[$], q_dt[$];
  bit q_b[$];

  function automatic int dz(int v, int t);
    int m = (v < 0) ? -v : v;
    return (m < t) ? 0 : v;
  endfunction

  function automatic int clip(int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  function automatic int s9(logic [8:0] v);
    return int'($signed(v));
  endfunction

  task automatic report_fail(string tag, int act, int exp);
    miscompares++;
    $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
  endtask

  // cycle-by-cycle comparison, sampled at the falling edge
  always @(negedge clk) begin
    if (started && !finished) begin
      bit exp_v;
      exp_v = (q_dx.size() > 0);
      vectors++;
      if (out_valid !== exp_v) report_fail("R6 R8 R9 out_valid", int'(out_valid), int'(exp_v));
      vectors++;
      if (in_ready !== (out_ready || !exp_v)) report_fail("R7 in_ready", int'(in_ready), int'(out_ready || !exp_v));
      if (out_valid && out_ready && exp_v) begin
        int edx, edy, edt;
        bit eb;
        edx = q_dx.pop_front(); edy = q_dy.pop_front();
        edt = q_dt.pop_front(); eb = q_b.pop_front();
        vectors += 4;
        if (s9(out_dx) != edx) report_fail("R1 R4 out_dx", s9(out_dx), edx);
        if (s9(out_dy) != edy) report_fail("R2 R4 out_dy", s9(out_dy), edy);
        if (s9(out_dt) != edt) report_fail("R3 R4 out_dt", s9(out_dt), edt);
        if (out_border !== eb) report_fail("R5 out_border", int'(out_border), int'(eb));
      end
      if (in_valid && in_ready) begin
        mk = in_sof ? 0 : (mk + 1) % NPX;
        pf[mk] = int'(in_prev);
        cf[mk] = int'(in_curr);
        if (mk >= W + 1) begin
          int c, cr, cc, t;
          c = mk - W - 1; cr = c / W; cc = c % W; t = int'(noise_floor);
          if (cr == 0 || cr == H - 1 || cc == 0 || cc == W - 1) begin
            q_dx.push_back(0); q_dy.push_back(0); q_dt.push_back(0); q_b.push_back(1'b1);
          end else begin
            q_dx.push_back(dz((pf[c+1] - pf[c-1]) >>> 1, t));
            q_dy.push_back(dz((pf[c+W] - pf[c-W]) >>> 1, t));
            q_dt.push_back(dz(cf[c] - pf[c], t));
            q_b.push_back(1'b0);
          end
        end
      end
    end
  end

  // downstream ready driver
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: out_ready = ($urandom % 4) != 0;
        default: out_ready = ($urandom % 4) == 0;
      endcase
    end
  end

  task automatic send_px(input bit sof, input int p, input int cu);
    bit acc;
    in_valid = 1'b1; in_sof = sof; in_prev = 8'(p); in_curr = 8'(cu);
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_sof = 1'b0;
    if (gap_mode && ($urandom % 3 == 0)) begin @(posedge clk); #1; end
  endtask

  task automatic send_frame(input int mode, input int npx);
    for (int k = 0; k < npx; k++) begin
      int r, c, p, cu;
      r = k / W; c = k % W;
      case (mode)
        0: begin p = c * 9 + r * 3; cu = clip(p + (k % 13) - 6); end
        1: begin p = int'($urandom % 256); cu = int'($urandom % 256); end
        2: begin p = ((c % 4) < 2) ? 0 : 255; cu = (r % 2 == 0) ? 255 - p : p; end
        default: begin
          p = c * 10 + r * 20;
          case (k % 4)
            0: cu = clip(p + 10);
            1: cu = clip(p - 10);
            2: cu = clip(p + 9);
            default: cu = clip(p - 9);
          endcase
        end
      endcase
      send_px(k == 0, p, cu);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0;
    in_prev = '0; in_curr = '0; noise_floor = 8'd5;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 started = 1'b1;   // first monitored cycles cover the R8 idle state
    repeat (3) @(posedge clk); #1;

    noise_floor = 8'd5;  rdy_mode = 0; gap_mode = 0;
    send_frame(0, NPX);
    send_frame(1, NPX);
    rdy_mode = 1; gap_mode = 1;
    send_frame(1, NPX);
    send_frame(2, NPX);
    noise_floor = 8'd10; rdy_mode = 2;
    send_frame(3, NPX);
    rdy_mode = 1; gap_mode = 0;
    send_frame(3, NPX);
    noise_floor = 8'd0;
    send_frame(1, NPX);
    noise_floor = 8'd255; rdy_mode = 2; gap_mode = 1;
    send_frame(2, NPX);
    // R9: frame cut short, restarted by a mid-frame start-of-frame beat
    noise_floor = 8'd5; rdy_mode = 1;
    send_frame(1, 30);
    send_frame(0, NPX);
    send_frame(1, 2 * W + 3);
    send_frame(2, NPX);

    rdy_mode = 0;
    repeat (10) @(posedge clk);
    #1;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule